// File: doc/BRIEF.md
# Streaming Sum Reduction with Running Maximum

This block folds a stream of scalars into one single-precision (FP32) sum. A start pulse sets the element count and two options: whether the elements arrive as BF16 values or as signed 8-bit integers, and whether the pass should also track the largest element. After the start, the block takes exactly one element per accepted valid/ready handshake. Once it has taken the programmed number of elements, it emits the sum together with a one-cycle completion pulse.

With maximum tracking on, a shared maximum register is reset to negative infinity at the start of the pass and raised by every larger element. The register keeps its value after the pass, so a later exponential step can subtract the maximum (the usual numerically safe softmax). The softmax front end then needs only this one pass over the data. The upstream stage delivers scalars that are already reduced, so this unit only accumulates.

Top module: `rsum_reduce_top`

## Requirements
- R1: When idle, `start_i` with a nonzero `len_i` makes `in_ready_o` go high on the next cycle. The block then takes exactly `len_i` elements, one per cycle in which `in_valid_i` and `in_ready_o` are both high.
- R2: The accumulator is cleared to +0 (0x00000000) at every start, and each element is added to it in FP32. The emitted sum equals the FP32 sum of the elements taken.
- R3: With `int8_mode_i` low at the start, `in_data_i[15:0]` is a BF16 value. It is widened to FP32 by placing it in bits 31:16 and zero-filling bits 15:0.
- R4: With `int8_mode_i` high at the start, `in_data_i[7:0]` is a two's-complement integer (-128..127) converted exactly to FP32, and `in_data_i[15:8]` is ignored.
- R5: Each addition rounds to nearest with ties to even. Operands and results with a zero exponent field are flushed to zero.
- R6: On the cycle after the last handshake, `sum_valid_o` is high for exactly one cycle and `sum_o` carries the sum. `in_ready_o` is low in that cycle, and `sum_o` keeps its value while the block is idle.
- R7: With `findmax_i` high at a start with nonzero length, `emax_o` becomes negative infinity (0xFF800000) on the next cycle. It then takes the larger of itself and each element taken, and keeps the final maximum after the pass.
- R8: With `findmax_i` low at the start, `emax_o` is not changed by the pass.
- R9: A start with `len_i` equal to zero gives `sum_valid_o` high with `sum_o` = +0 on the next cycle, leaves `emax_o` unchanged and never raises `in_ready_o`.
- R10: `start_i` is ignored while a pass is in progress, and `in_valid_i` is ignored while the block is idle.
- R11: Cycles with `in_valid_i` low during a pass take no element and do not shorten the pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a pass (accepted only when idle) |
| len_i | input | LEN_W | Number of elements in the pass |
| findmax_i | input | 1 | Track the maximum during this pass |
| int8_mode_i | input | 1 | 1: signed 8-bit elements, 0: BF16 elements |
| in_valid_i | input | 1 | Element on `in_data_i` is valid |
| in_data_i | input | 16 | Element data |
| in_ready_o | output | 1 | Block is in a pass and accepts elements |
| sum_valid_o | output | 1 | One-cycle completion pulse |
| sum_o | output | 32 | FP32 sum |
| emax_o | output | 32 | FP32 shared maximum register |

## Verification
The bound checker checks the cycle-level protocol on every cycle. It covers the one-cycle completion pulse and `in_ready_o` being low with it, `in_ready_o` rising after an accepted start, the immediate +0 result for a zero length, the negative-infinity preset of the maximum, and the sum and maximum holding while idle. Only the bench's scenarios can show the arithmetic: exact INT8 conversion with garbage in the upper byte, BF16 widening, fractional alignment, cancellation to zero, and tie-to-even rounding at 2^24. The same applies to the order-dependent results: the element count surviving valid gaps and an ignored mid-pass start, and the maximum carried across a pass without tracking.

// File: rtl/rsum_pkg.sv
package rsum_pkg;
    typedef logic [31:0] fp32_t;
    localparam fp32_t FP_POS_ZERO = 32'h0000_0000;
    localparam fp32_t FP_NEG_INF  = 32'hFF80_0000;
    localparam int    EXT_W       = 27;   // 24 significand bits + guard, round, sticky
endpackage

// File: rtl/rsum_elem_conv.sv
module rsum_elem_conv
    import rsum_pkg::*;
(
    input  logic        int8_mode,
    input  logic [15:0] raw,
    output fp32_t       fp
);
    logic        sgn;
    logic [7:0]  mag;
    logic [2:0]  msb;
    logic [22:0] man;

    always_comb begin
        sgn = raw[7];
        mag = sgn ? (~raw[7:0] + 8'd1) : raw[7:0];
        msb = 3'd0;
        for (int i = 0; i < 8; i++) begin
            if (mag[i]) msb = 3'(i);
        end
        man = 23'(mag) << (5'd23 - {2'b00, msb});
        if (!int8_mode) begin
            fp = {raw, 16'h0000};
        end else if (mag == 8'd0) begin
            fp = FP_POS_ZERO;
        end else begin
            fp = {sgn, 8'd127 + {5'b00000, msb}, man};
        end
    end
endmodule

// File: rtl/rsum_fp32_add.sv
module rsum_fp32_add
    import rsum_pkg::*;
(
    input  fp32_t a,
    input  fp32_t b,
    output fp32_t y
);
    fp32_t              big, sml;
    logic [7:0]         eb, es, dif;
    logic [EXT_W-1:0]   mb, ms, msh, lost, m27;
    logic [EXT_W:0]     s28;
    logic [24:0]        m25;
    logic               sub, zero_res, up;
    logic [4:0]         msb, lz;
    logic signed [9:0]  ef;

    always_comb begin
        big      = (b[30:0] > a[30:0]) ? b : a;
        sml      = (b[30:0] > a[30:0]) ? a : b;
        eb       = big[30:23];
        es       = sml[30:23];
        dif      = eb - es;
        mb       = {1'b1, big[22:0], 3'b000};
        ms       = {1'b1, sml[22:0], 3'b000};
        msh      = '0;
        lost     = '0;
        s28      = '0;
        m27      = '0;
        m25      = '0;
        msb      = '0;
        lz       = '0;
        up       = 1'b0;
        zero_res = 1'b0;
        sub      = big[31] ^ sml[31];
        ef       = signed'({2'b00, eb});
        y        = FP_POS_ZERO;

        if (eb == 8'hFF) begin
            y = big;
        end else if (es == 8'd0) begin
            y = (eb == 8'd0) ? FP_POS_ZERO : big;
        end else begin
            // align the smaller operand, folding shifted-out bits into sticky
            if (dif >= 8'(EXT_W)) begin
                msh = {{(EXT_W-1){1'b0}}, 1'b1};
            end else begin
                msh  = ms >> dif;
                lost = ms & ((27'd1 << dif) - 27'd1);
                msh[0] = msh[0] | (|lost);
            end
            if (!sub) begin
                s28 = {1'b0, mb} + {1'b0, msh};
                if (s28[EXT_W]) begin
                    m27    = s28[EXT_W:1];
                    m27[0] = m27[0] | s28[0];
                    ef     = ef + 10'sd1;
                end else begin
                    m27 = s28[EXT_W-1:0];
                end
            end else begin
                m27 = mb - msh;
                if (m27 == '0) begin
                    zero_res = 1'b1;
                end else begin
                    for (int i = 0; i < EXT_W; i++) begin
                        if (m27[i]) msb = 5'(i);
                    end
                    lz  = 5'(EXT_W - 1) - msb;
                    m27 = m27 << lz;
                    ef  = ef - signed'({5'b00000, lz});
                end
            end
            // round to nearest, ties to even
            up  = m27[2] & (m27[1] | m27[0] | m27[3]);
            m25 = {1'b0, m27[EXT_W-1:3]} + {24'd0, up};
            if (m25[24]) begin
                m25 = m25 >> 1;
                ef  = ef + 10'sd1;
            end
            if (zero_res) begin
                y = FP_POS_ZERO;
            end else if (ef >= 10'sd255) begin
                y = {big[31], 8'hFF, 23'd0};
            end else if (ef <= 10'sd0) begin
                y = {big[31], 31'd0};
            end else begin
                y = {big[31], ef[7:0], m25[22:0]};
            end
        end
    end
endmodule

// File: rtl/rsum_fp32_max.sv
module rsum_fp32_max
    import rsum_pkg::*;
(
    input  fp32_t a,
    input  fp32_t b,
    output fp32_t y
);
    logic [31:0] ka, kb;

    always_comb begin
        // map sign-magnitude onto an unsigned total order
        ka = a[31] ? ~a : {1'b1, a[30:0]};
        kb = b[31] ? ~b : {1'b1, b[30:0]};
        y  = (kb > ka) ? b : a;
    end
endmodule

// File: rtl/rsum_reduce_top.sv
module rsum_reduce_top
    import rsum_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic             findmax_i,
    input  logic             int8_mode_i,
    input  logic             in_valid_i,
    input  logic [15:0]      in_data_i,
    output logic             in_ready_o,
    output logic             sum_valid_o,
    output logic [31:0]      sum_o,
    output logic [31:0]      emax_o
);
    localparam logic [LEN_W-1:0] LEN_ONE = LEN_W'(1);

    typedef struct packed {
        logic             busy;
        logic             track;
        logic             int8;
        logic             done;
        logic [LEN_W-1:0] left;
        fp32_t            acc;
        fp32_t            emax;
    } state_t;

    state_t s_d, s_q;
    fp32_t  elem_fp, add_res, max_res;

    rsum_elem_conv u_conv (
        .int8_mode (s_q.int8),
        .raw       (in_data_i),
        .fp        (elem_fp)
    );

    rsum_fp32_add u_add (
        .a (s_q.acc),
        .b (elem_fp),
        .y (add_res)
    );

    rsum_fp32_max u_max (
        .a (s_q.emax),
        .b (elem_fp),
        .y (max_res)
    );

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        if (!s_q.busy) begin
            if (start_i) begin
                s_d.int8  = int8_mode_i;
                s_d.track = findmax_i;
                s_d.acc   = FP_POS_ZERO;
                if (len_i == '0) begin
                    s_d.done = 1'b1;
                end else begin
                    s_d.busy = 1'b1;
                    s_d.left = len_i;
                    if (findmax_i) s_d.emax = FP_NEG_INF;
                end
            end
        end else if (in_valid_i) begin
            s_d.acc  = add_res;
            s_d.left = s_q.left - LEN_ONE;
            if (s_q.track) s_d.emax = max_res;
            if (s_q.left == LEN_ONE) begin
                s_d.busy = 1'b0;
                s_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign in_ready_o  = s_q.busy;
    assign sum_valid_o = s_q.done;
    assign sum_o       = s_q.acc;
    assign emax_o      = s_q.emax;
endmodule

// File: rtl/rsum_reduce_chk.sv
module rsum_reduce_chk #(
    parameter int LEN_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic [LEN_W-1:0] len_i,
    input logic             findmax_i,
    input logic             in_ready_o,
    input logic             sum_valid_o,
    input logic [31:0]      sum_o,
    input logic [31:0]      emax_o
);
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        sum_valid_o |=> !sum_valid_o);

    a_r6_ready_low_at_result: assert property (@(posedge clk) disable iff (!rst_n)
        sum_valid_o |-> !in_ready_o);

    a_r1_ready_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_ready_o && start_i && len_i != '0) |=> in_ready_o);

    a_r9_zero_length: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_ready_o && start_i && len_i == '0)
        |=> (sum_valid_o && sum_o == 32'h0 && !in_ready_o && $stable(emax_o)));

    a_r7_max_preset: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_ready_o && start_i && findmax_i && len_i != '0) |=> (emax_o == 32'hFF80_0000));

    a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_ready_o && !start_i) |=> ($stable(emax_o) && $stable(sum_o) && !in_ready_o));
endmodule

bind rsum_reduce_top rsum_reduce_chk #(.LEN_W(LEN_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .len_i       (len_i),
    .findmax_i   (findmax_i),
    .in_ready_o  (in_ready_o),
    .sum_valid_o (sum_valid_o),
    .sum_o       (sum_o),
    .emax_o      (emax_o)
);

// File: tb/rsum_reduce_top_bench.sv
`timescale 1ns/1ps
module rsum_reduce_top_bench;
    localparam int LEN_W = 16;
    localparam int MAXN  = 256;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [LEN_W-1:0] len_i = '0;
    logic             findmax_i = 1'b0;
    logic             int8_mode_i = 1'b0;
    logic             in_valid_i = 1'b0;
    logic [15:0]      in_data_i = '0;
    logic             in_ready_o, sum_valid_o;
    logic [31:0]      sum_o, emax_o;

    always #4 clk = ~clk;

    rsum_reduce_top #(.LEN_W(LEN_W)) u_rsum_reduce_top (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .len_i(len_i),
        .findmax_i(findmax_i), .int8_mode_i(int8_mode_i), .in_valid_i(in_valid_i),
        .in_data_i(in_data_i), .in_ready_o(in_ready_o), .sum_valid_o(sum_valid_o),
        .sum_o(sum_o), .emax_o(emax_o)
    );

    typedef struct {
        logic [31:0] sum;
        logic [31:0] emax;
        string       req;
    } exp_t;

    exp_t        sb_q[$];
    int          n_cmp = 0, n_bad = 0, n_results = 0, n_pushed = 0;
    bit          done_flag = 0;
    logic [15:0] raw[MAXN];
    logic [31:0] cur_max = 32'h0;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, expv);
        end
    endtask

    function automatic logic [31:0] i2f(input int v);
        int m; int p; logic [31:0] sh;
        if (v == 0) return 32'h0;
        m = (v < 0) ? -v : v;
        p = 0;
        for (int i = 0; i < 24; i++) if (m[i]) p = i;
        sh = 32'(m) << (23 - p);
        return {(v < 0), 8'(127 + p), sh[22:0]};
    endfunction

    function automatic logic [15:0] bf(input int v);
        logic [31:0] f;
        f = i2f(v);
        return f[31:16];
    endfunction

    // driver: pushes the expected item, then plays the pass
    task automatic run_pass(input bit m8, input bit fm, input int n,
                            input logic [31:0] esum, input logic [31:0] emx,
                            input string req, input bit gap, input bit mid_start);
        exp_t e;
        e.sum = esum; e.emax = emx; e.req = req;
        sb_q.push_back(e);
        n_pushed++;
        @(negedge clk);
        start_i = 1'b1; len_i = LEN_W'(n); findmax_i = fm; int8_mode_i = m8;
        @(negedge clk);
        start_i = 1'b0;
        if (n > 0) check(in_ready_o == 1'b1, "R1 ready after start", {31'd0, in_ready_o}, 32'd1);
        for (int i = 0; i < n; i++) begin
            if (gap && (i % 2 == 1)) begin
                in_valid_i = 1'b0;
                in_data_i  = 16'h4F00;
                @(negedge clk);
            end
            in_valid_i = 1'b1;
            in_data_i  = raw[i];
            if (mid_start && i == 2) begin
                start_i = 1'b1; len_i = LEN_W'(1); findmax_i = 1'b0;
            end
            @(negedge clk);
            start_i = 1'b0;
        end
        in_valid_i = 1'b0;
        check(in_ready_o == 1'b0, "R1 ready low after len elements", {31'd0, in_ready_o}, 32'd0);
        repeat (3) @(negedge clk);
    endtask

    // monitor: pops and compares as results appear
    initial begin
        bit prev = 0;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (sum_valid_o) begin
                    exp_t e;
                    n_results++;
                    check(!prev, "R6 pulse one cycle", 32'd1, 32'd0);
                    check(!in_ready_o, "R6 ready low with result", {31'd0, in_ready_o}, 32'd0);
                    if (sb_q.size() == 0) begin
                        check(1'b0, "R10 unexpected result", sum_o, 32'hFFFF_FFFF);
                    end else begin
                        e = sb_q.pop_front();
                        check(sum_o == e.sum, {e.req, " sum"}, sum_o, e.sum);
                        check(emax_o == e.emax, {e.req, " emax"}, emax_o, e.emax);
                    end
                end
                prev = sum_valid_o;
            end
        end
    end

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "watchdog expired", 32'd0, 32'd1);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(in_ready_o == 1'b0, "reset ready", {31'd0, in_ready_o}, 32'd0);
        check(sum_valid_o == 1'b0, "reset valid", {31'd0, sum_valid_o}, 32'd0);
        check(sum_o == 32'h0, "reset sum", sum_o, 32'h0);
        check(emax_o == 32'h0, "reset emax", emax_o, 32'h0);

        // R3 R2 R7: BF16 with tracking
        raw[0] = bf(3); raw[1] = bf(-5); raw[2] = bf(7); raw[3] = bf(2);
        cur_max = i2f(7);
        run_pass(0, 1, 4, i2f(7), cur_max, "R3 bf16 sum", 0, 0);

        // R4: INT8 with garbage in upper byte, extremes
        raw[0] = {8'hC3, 8'h80}; raw[1] = {8'h5A, 8'h7F};
        raw[2] = {8'hFF, 8'hFF}; raw[3] = {8'h11, 8'h0A};
        cur_max = i2f(127);
        run_pass(1, 1, 4, i2f(8), cur_max, "R4 int8 exact", 0, 0);

        // R8: no tracking leaves maximum
        raw[0] = bf(1); raw[1] = bf(2); raw[2] = bf(3);
        run_pass(0, 0, 3, i2f(6), cur_max, "R8 emax kept", 0, 0);

        // R9: zero length with tracking requested
        run_pass(0, 1, 0, 32'h0, cur_max, "R9 zero length", 0, 0);

        // R7: all negative, preset must be below every element
        raw[0] = {8'h00, 8'hFD}; raw[1] = {8'h00, 8'hF7}; raw[2] = {8'h00, 8'hFF};
        cur_max = i2f(-1);
        run_pass(1, 1, 3, i2f(-13), cur_max, "R7 negative max", 0, 0);

        // R11: valid gaps
        for (int i = 0; i < 5; i++) raw[i] = bf(10 * (i + 1));
        cur_max = i2f(50);
        run_pass(0, 1, 5, i2f(150), cur_max, "R11 gaps", 1, 0);

        // R10: start during a pass is ignored
        for (int i = 0; i < 4; i++) raw[i] = bf(4);
        cur_max = i2f(4);
        run_pass(0, 1, 4, i2f(16), cur_max, "R10 mid start", 0, 1);

        // R10: input while idle is ignored
        @(negedge clk);
        in_valid_i = 1'b1; in_data_i = bf(100);
        repeat (3) @(negedge clk);
        in_valid_i = 1'b0;
        check(sum_o == i2f(16), "R10 idle input sum", sum_o, i2f(16));
        check(emax_o == cur_max, "R10 idle input emax", emax_o, cur_max);
        raw[0] = bf(1);
        cur_max = i2f(1);
        run_pass(0, 1, 1, i2f(1), cur_max, "R10 after idle input", 0, 0);

        // R5: ties to even at 2^24
        raw[0] = 16'h4B80; raw[1] = bf(1); raw[2] = bf(1);
        run_pass(0, 0, 3, 32'h4B80_0000, cur_max, "R5 tie to even", 0, 0);

        // R2: cancellation gives +0, fractional alignment
        raw[0] = bf(5); raw[1] = bf(-5);
        cur_max = i2f(5);
        run_pass(0, 1, 2, 32'h0, cur_max, "R2 cancel", 0, 0);
        raw[0] = 16'h3F00; raw[1] = 16'h3E80;
        cur_max = 32'h3F00_0000;
        run_pass(0, 1, 2, 32'h3F40_0000, cur_max, "R2 fraction", 0, 0);

        // R1: long pass, exact count
        for (int i = 0; i < 200; i++) raw[i] = {8'h00, 8'h7F};
        cur_max = i2f(127);
        run_pass(1, 1, 200, i2f(25400), cur_max, "R1 long pass", 0, 0);

        repeat (5) @(negedge clk);
        check(sb_q.size() == 0, "R10 results outstanding", 32'(sb_q.size()), 32'd0);
        check(n_results == n_pushed, "R10 result count", 32'(n_results), 32'(n_pushed));
        check(sum_o == i2f(25400), "R6 sum held idle", sum_o, i2f(25400));
        finish_run();
    end
endmodule